// File: doc/BRIEF.md
# Warning Sign Lamp Sequencer

This block lights a five-lamp warning sign in a repeating build-up pattern while an enable switch is held on. The lamps are wired in three groups: an inner pair (lamps 1 and 2), an outer pair (lamps 3 and 4) and a single tip lamp (lamp 5). Each step, one more group comes on: the inner pair, then both pairs, then every lamp. The step after that is fully dark, and then the pattern starts again.

The block is a Moore machine with four named states held in two flip-flops: `ST_DARK` (2'b00), `ST_INNER` (2'b01), `ST_OUTER` (2'b10) and `ST_FULL` (2'b11). While the switch is on, the transitions are *advance* (DARK→INNER, INNER→OUTER, OUTER→FULL) and *wrap* (FULL→DARK). When the switch is off, every state takes the *release* transition to DARK. The lamp outputs are decoded from the present state only. The block moves one step on each clock edge. A slower blink rate has to come from the clock that feeds it.

Top module: `sign_seq`

## Requirements
- R1: An active-high reset sampled at a rising clock edge puts the machine in ST_DARK, with all three lamp outputs at 0 after that edge, whatever the switch does.
- R2: With the switch at 1, each rising edge moves the state one step along DARK→INNER→OUTER→FULL→DARK.
- R3: With the switch at 0 at a rising edge, the next state is ST_DARK from any state, so all lamps are off after that edge.
- R4: The inner-pair output (lamps 1 and 2) is 1 exactly in states 2'b01, 2'b10 and 2'b11.
- R5: The outer-pair output (lamps 3 and 4) is 1 exactly in states 2'b10 and 2'b11.
- R6: The tip output (lamp 5) is 1 only in state 2'b11.
- R7: The lamp outputs depend on the present state only: a change of the switch between clock edges leaves them unchanged until the next edge.
- R8: When the switch is turned on in ST_DARK, the inner pair lights after the very next rising edge.
- R9: The lit groups are nested: the tip lamp is never on without the outer pair, and the outer pair is never on without the inner pair. While the switch is on, each advance lights exactly one more group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pattern step per rising edge |
| rst | input | 1 | Synchronous active-high reset to ST_DARK |
| sw_on | input | 1 | Enable switch; 1 runs the pattern, 0 forces dark |
| lamp_inner | output | 1 | Drives lamps 1 and 2 |
| lamp_outer | output | 1 | Drives lamps 3 and 4 |
| lamp_tip | output | 1 | Drives lamp 5 |

## Verification
The bench targets four corner cases:
- Releasing the switch in each of the four states. A design that decremented the state, or held it, would leave lamps lit after the release edge.
- Several full wraps from FULL back to DARK. An off-by-one decode would light the tip lamp in the wrong step, or skip the dark step.
- Reset asserted mid-pattern with the switch still on. A reset that was ignored, or that waited for the switch, would keep the pattern running.
- Toggling the switch between edges. A Mealy-style leak of the switch into the outputs would show up at once as a lamp change with no clock edge.

// File: rtl/sign_seq_pkg.sv
package sign_seq_pkg;

    localparam int STEP_W = 2;

    typedef enum logic [STEP_W-1:0] {
        ST_DARK  = 2'b00,
        ST_INNER = 2'b01,
        ST_OUTER = 2'b10,
        ST_FULL  = 2'b11
    } step_t;

    typedef struct packed {
        logic inner;
        logic outer;
        logic tip;
    } lamps_t;

    localparam int LAMP_W = $bits(lamps_t);

endpackage

// File: rtl/sign_step_fsm.sv
module sign_step_fsm
    import sign_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sw_on,
    output step_t step
);

    step_t step_nxt;

    // next-state selection: advance / wrap while switch on, release when off
    always_comb begin
        step_nxt = ST_DARK;
        if (sw_on) begin
            unique case (step)
                ST_DARK:  step_nxt = ST_INNER;
                ST_INNER: step_nxt = ST_OUTER;
                ST_OUTER: step_nxt = ST_FULL;
                ST_FULL:  step_nxt = ST_DARK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) step <= ST_DARK;
        else     step <= step_nxt;
    end

    // R1: reset always lands in the dark state
    a_r1_reset_dark: assert property (@(posedge clk)
        rst |=> step == ST_DARK);

    // R2: one step forward per edge while the switch is on, wrapping at FULL
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        sw_on |=> step == step_t'($past(step) + 2'd1));

    // R3: release returns to dark from anywhere
    a_r3_release_dark: assert property (@(posedge clk) disable iff (rst)
        !sw_on |=> step == ST_DARK);

    // R8: dark plus switch on gives the first lit state next
    a_r8_first_lit: assert property (@(posedge clk) disable iff (rst)
        (sw_on && step == ST_DARK) |=> step == ST_INNER);

endmodule

// File: rtl/sign_lamp_decode.sv
module sign_lamp_decode
    import sign_seq_pkg::*;
(
    input  step_t  step,
    output lamps_t lamps
);

    always_comb begin
        lamps = '0;
        unique case (step)
            ST_DARK:  lamps = '{inner: 1'b0, outer: 1'b0, tip: 1'b0};
            ST_INNER: lamps = '{inner: 1'b1, outer: 1'b0, tip: 1'b0};
            ST_OUTER: lamps = '{inner: 1'b1, outer: 1'b1, tip: 1'b0};
            ST_FULL:  lamps = '{inner: 1'b1, outer: 1'b1, tip: 1'b1};
        endcase
    end

endmodule

// File: rtl/sign_seq.sv
module sign_seq
    import sign_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_on,
    output logic lamp_inner,
    output logic lamp_outer,
    output logic lamp_tip
);

    step_t  step;
    lamps_t lamps;

    sign_step_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sw_on (sw_on),
        .step  (step)
    );

    sign_lamp_decode u_dec (
        .step  (step),
        .lamps (lamps)
    );

    assign lamp_inner = lamps.inner;
    assign lamp_outer = lamps.outer;
    assign lamp_tip   = lamps.tip;

    // R9: groups are nested, tip needs outer, outer needs inner
    a_r9_nested: assert property (@(posedge clk) disable iff (rst)
        (lamp_tip |-> lamp_outer) and (lamp_outer |-> lamp_inner));

    // R9: each advance below FULL lights exactly one more group
    a_r9_one_more: assert property (@(posedge clk) disable iff (rst)
        (sw_on && step != ST_FULL) |=>
            $countones(lamps) == $countones($past(lamps)) + 1);

    // R7: lamps move only when the state moves
    a_r7_state_only: assert property (@(posedge clk) disable iff (rst)
        $stable(step) |-> $stable(lamps));

    // R3: after a release edge every lamp is dark
    a_r3_lamps_off: assert property (@(posedge clk) disable iff (rst)
        !sw_on |=> lamps == '0);

endmodule

// File: tb/sign_seq_bench.sv
`timescale 1ns/1ps
module sign_seq_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_on = 1'b0;
    logic lamp_inner, lamp_outer, lamp_tip;

    int total = 0;
    int bad = 0;
    int ref_step = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sign_seq u_sign_seq (
        .clk        (clk),
        .rst        (rst),
        .sw_on      (sw_on),
        .lamp_inner (lamp_inner),
        .lamp_outer (lamp_outer),
        .lamp_tip   (lamp_tip)
    );

    task automatic check(input string req);
        logic e_in, e_out, e_tip;
        e_in  = (ref_step != 0);
        e_out = (ref_step >= 2);
        e_tip = (ref_step == 3);
        total++;
        if ({lamp_inner, lamp_outer, lamp_tip} !== {e_in, e_out, e_tip}) begin
            bad++;
            $display("FAIL %s step=%0d actual=%b%b%b expected=%b%b%b", req, ref_step,
                     lamp_inner, lamp_outer, lamp_tip, e_in, e_out, e_tip);
        end
    endtask

    // one clock: apply inputs, update the model at the edge, compare after it
    task automatic tick(input logic r, input logic s, input string req);
        rst = r;
        sw_on = s;
        @(posedge clk);
        #1;
        if (r)      ref_step = 0;
        else if (s) ref_step = (ref_step + 1) % 4;
        else        ref_step = 0;
        check(req);
    endtask

    initial begin
        // R1: reset state, switch on during reset
        tick(1'b1, 1'b1, "R1");
        tick(1'b1, 1'b0, "R1");
        // R8: first lit state right after switch on
        tick(1'b0, 1'b1, "R8");
        // R2, R4, R5, R6: several full wraps
        for (int i = 0; i < 11; i++) tick(1'b0, 1'b1, "R2");
        // R3: release from each state
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, 1'b0, "R3");
            for (int j = 0; j < k; j++) tick(1'b0, 1'b1, "R4");
            tick(1'b0, 1'b0, "R3");
        end
        // R5/R6: walk to FULL and hold checks on each decode
        tick(1'b0, 1'b1, "R4");
        tick(1'b0, 1'b1, "R5");
        tick(1'b0, 1'b1, "R6");
        // R7: toggle switch between edges, lamps must not move
        sw_on = 1'b0;
        #1 check("R7");
        sw_on = 1'b1;
        #1 check("R7");
        tick(1'b0, 1'b1, "R9");
        tick(1'b0, 1'b1, "R9");
        tick(1'b0, 1'b1, "R9");
        // R1: reset mid-pattern with switch still on
        tick(1'b1, 1'b1, "R1");
        tick(1'b0, 1'b1, "R8");
        tick(1'b0, 1'b1, "R2");
        tick(1'b0, 1'b1, "R2");
        tick(1'b0, 1'b1, "R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule